// File: doc/BRIEF.md
# Serialized PWM Word Generator

This block produces a 12-bit-resolution pulse-width waveform without comparing a counter against the duty value on every tick. The 4096-tick period is split into 128 chunks of 32 ticks. For each chunk a word source computes, from the active duty value, the 32-bit pattern that chunk must show. That pattern can be all zeros, all ones, or ones in the low bits followed by zeros. The word is handed to a serializer that has a holding register in front of a shift register. The serializer sends out one bit per clock, least significant bit first.

Duty values arrive on a valid/ready stream. An accepted value is parked in a pending slot and becomes active only when the first word of a new period is produced, so no period mixes two duty values. While a value is waiting, `duty_ready` stays low and the upstream must hold `duty_valid` and `duty_data` steady until a transfer occurs (valid and ready high at the same rising edge). The `enable` input gates word production. If production stops, the shifter drains what it holds and then raises a sticky underrun flag while the output keeps its last level.

Top module: `spwm_word_gen`

## Requirements
- R1: While reset is held and just after it, `pwm_out` is 0, `underrun` is 0 and `duty_ready` is 1, and the active duty value is 0.
- R2: With `enable` high, the output forms a repeating period of exactly 4096 clocks: 128 words of 32 bits, one bit per clock, bit 0 of each word first, and no idle clock between words.
- R3: Every word is all zeros, all ones, or a block of ones in bits 0 upward followed only by zeros. Bit i of the word for chunk k is 1 exactly when k*32+i is less than the active duty.
- R4: Each period the output is high for the first `duty` clocks and then low for the remaining 4096-duty clocks. A duty of 0 keeps the output low, and a duty of 4095 leaves a single low clock per period.
- R5: A duty value taken from the stream becomes active only when the word for chunk 0 of a period is produced, and it then governs that whole period.
- R6: Once a duty value has been accepted and is not yet active, `duty_ready` is 0 and a further offer is stalled. The stalled offer is accepted only after the pending value becomes active.
- R7: The holding register is refilled while the shifter emits. When the last bit of a word leaves and a word is waiting, the next word starts on the following clock, so `underrun` stays 0 in normal running.
- R8: If the shifter finishes a word and no word is waiting, `underrun` goes to 1 and stays 1 until reset, and `pwm_out` holds its last value for as long as no word is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one output tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows the word source to produce words |
| duty_valid | input | 1 | Duty stream valid |
| duty_ready | output | 1 | Duty stream ready; low while a value is pending |
| duty_data | input | 12 | Duty value in ticks, 0 to 4095 |
| pwm_out | output | 1 | Serial PWM waveform |
| underrun | output | 1 | Sticky flag: the shifter ran dry |

## Verification
Two events can land in the same clock. The shifter can drain the last bit of a word on the same edge that the word source pushes a new word into the holding register. That same push can be the chunk-0 word that activates a pending duty value. The bench makes both happen all the time by running long stretches with different duty values, including values on word boundaries (31, 32, 33, 4064) and the extremes. It judges the result from the exact lengths of the high and low runs in the first period after each change, which must match the new duty with no lost or repeated tick. A stalled second offer and a stop of word production cover the back-pressure and starvation paths.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  parameter int unsigned SPWM_RES_W  = 12;
  parameter int unsigned SPWM_WORD_W = 32;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } spwm_sh_state_e;
endpackage

// File: rtl/spwm_pattern.sv
module spwm_pattern #(
  parameter int unsigned RES_W  = spwm_pkg::SPWM_RES_W,
  parameter int unsigned WORD_W = spwm_pkg::SPWM_WORD_W,
  localparam int unsigned SHIFT_W = $clog2(WORD_W),
  localparam int unsigned CHUNK_W = RES_W - SHIFT_W
) (
  input  logic [CHUNK_W-1:0] chunk,
  input  logic [RES_W-1:0]   duty,
  output logic [WORD_W-1:0]  word
);
  // Each bit position compares its absolute tick number against the duty.
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    localparam logic [SHIFT_W-1:0] POS = SHIFT_W'(i);
    assign word[i] = ({chunk, POS} < duty);
  end
endmodule

// File: rtl/spwm_word_source.sv
module spwm_word_source #(
  parameter int unsigned RES_W  = spwm_pkg::SPWM_RES_W,
  parameter int unsigned WORD_W = spwm_pkg::SPWM_WORD_W,
  localparam int unsigned SHIFT_W = $clog2(WORD_W),
  localparam int unsigned CHUNK_W = RES_W - SHIFT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              duty_valid,
  output logic              duty_ready,
  input  logic [RES_W-1:0]  duty_data,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word_data
);
  localparam logic [CHUNK_W-1:0] LAST_CHUNK = '1;
  localparam logic [CHUNK_W-1:0] CHUNK_ONE  = CHUNK_W'(1);

  logic [CHUNK_W-1:0] chunk_q;
  logic [RES_W-1:0]   duty_cur_q;
  logic [RES_W-1:0]   pend_q;
  logic               pend_vld_q;
  logic [RES_W-1:0]   eff_duty;
  logic               period_start;
  logic               push;
  logic               take_pend;

  assign period_start = (chunk_q == '0);
  assign eff_duty     = (period_start && pend_vld_q) ? pend_q : duty_cur_q;
  assign word_valid   = enable;
  assign push         = word_valid && word_ready;
  assign take_pend    = push && period_start && pend_vld_q;
  assign duty_ready   = !pend_vld_q;

  spwm_pattern #(.RES_W(RES_W), .WORD_W(WORD_W)) u_pattern (
    .chunk (chunk_q),
    .duty  (eff_duty),
    .word  (word_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chunk_q    <= '0;
      duty_cur_q <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (duty_valid && duty_ready) begin
        pend_q     <= duty_data;
        pend_vld_q <= 1'b1;
      end else if (take_pend) begin
        pend_vld_q <= 1'b0;
      end
      if (push) begin
        chunk_q <= (chunk_q == LAST_CHUNK) ? '0 : chunk_q + CHUNK_ONE;
        if (period_start) duty_cur_q <= eff_duty;
      end
    end
  end

  AST_WORD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (($countones(word_data[WORD_W-2:0] ^ word_data[WORD_W-1:1]) <= 1)
                    && (word_data[0] || (word_data == '0)))); // R3

  AST_CHUNK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && chunk_q == LAST_CHUNK) |=> (chunk_q == '0)); // R2

  AST_DUTY_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && period_start) |=> $stable(duty_cur_q)); // R5

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld_q && !take_pend) |=> (pend_vld_q && $stable(pend_q) && !duty_ready)); // R6
endmodule

// File: rtl/spwm_serializer.sv
module spwm_serializer #(
  parameter int unsigned WORD_W = spwm_pkg::SPWM_WORD_W,
  localparam int unsigned SHIFT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              ser_out,
  output logic              underrun
);
  import spwm_pkg::*;

  localparam logic [SHIFT_W-1:0] CNT_ONE  = SHIFT_W'(1);
  localparam logic [SHIFT_W-1:0] CNT_LAST = '1;

  logic [WORD_W-1:0]  hold_q;
  logic               hold_full_q;
  logic [WORD_W-1:0]  shift_q;
  logic [SHIFT_W-1:0] cnt_q;
  spwm_sh_state_e     state_q;
  logic               out_q;
  logic               under_q;
  logic               last_bit;
  logic               consume;
  logic               push;

  assign last_bit = (state_q == SH_RUN) && (cnt_q == CNT_LAST);
  assign consume  = hold_full_q && ((state_q == SH_IDLE) || last_bit);
  assign in_ready = !hold_full_q || consume;
  assign push     = in_valid && in_ready;
  assign ser_out  = out_q;
  assign underrun = under_q;

  // Holding register: written by the source, emptied by the shifter.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (push) begin
      hold_q      <= in_data;
      hold_full_q <= 1'b1;
    end else if (consume) begin
      hold_full_q <= 1'b0;
    end
  end

  // Shifter: one bit per clock, LSB first; reloads without a gap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      state_q <= SH_IDLE;
      out_q   <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (state_q == SH_RUN) begin
        out_q   <= shift_q[0];
        shift_q <= shift_q >> 1;
        cnt_q   <= cnt_q + CNT_ONE;
      end
      if (consume) begin
        shift_q <= hold_q;
        cnt_q   <= '0;
        state_q <= SH_RUN;
      end else if (last_bit) begin
        state_q <= SH_IDLE;
        under_q <= 1'b1;
      end
    end
  end

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && hold_full_q) |=> (state_q == SH_RUN && cnt_q == '0)); // R7

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full_q && !consume) |=> (hold_full_q && $stable(hold_q))); // R7

  AST_STARVED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_IDLE) |=> $stable(out_q)); // R8

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    under_q |=> under_q); // R8
endmodule

// File: rtl/spwm_word_gen.sv
module spwm_word_gen #(
  parameter int unsigned RES_W  = spwm_pkg::SPWM_RES_W,
  parameter int unsigned WORD_W = spwm_pkg::SPWM_WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             duty_valid,
  output logic             duty_ready,
  input  logic [RES_W-1:0] duty_data,
  output logic             pwm_out,
  output logic             underrun
);
  logic              w_valid;
  logic              w_ready;
  logic [WORD_W-1:0] w_data;

  spwm_word_source #(.RES_W(RES_W), .WORD_W(WORD_W)) u_source (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .duty_valid (duty_valid),
    .duty_ready (duty_ready),
    .duty_data  (duty_data),
    .word_valid (w_valid),
    .word_ready (w_ready),
    .word_data  (w_data)
  );

  spwm_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (w_valid),
    .in_ready (w_ready),
    .in_data  (w_data),
    .ser_out  (pwm_out),
    .underrun (underrun)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!pwm_out && !underrun && duty_ready)); // R1
endmodule

// File: tb/spwm_word_gen_tb.sv
module spwm_word_gen_tb_top;
  localparam int PERIOD = 4096;
  localparam int NVEC   = 10;
  localparam logic [11:0] DUTY_VEC [NVEC] = '{
    12'd100, 12'd0, 12'd1, 12'd31, 12'd32, 12'd33, 12'd64, 12'd2048, 12'd4064, 12'd4095
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        duty_valid = 1'b0;
  logic        duty_ready;
  logic [11:0] duty_data = '0;
  logic        pwm_out;
  logic        underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spwm_word_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .duty_valid(duty_valid), .duty_ready(duty_ready), .duty_data(duty_data),
    .pwm_out(pwm_out), .underrun(underrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic offer(input int d);
    @(negedge clk);
    duty_data  = 12'(d);
    duty_valid = 1'b1;
    while (!duty_ready) @(negedge clk);
    @(negedge clk);
    duty_valid = 1'b0;
  endtask

  // Waits for the offered value to go active, then times its first period.
  task automatic measure(input int d);
    int hi = 0;
    int lo = 0;
    int guard = 0;
    logic prev;
    while (!duty_ready) @(negedge clk);
    if (d == 0) begin
      repeat (64) @(negedge clk);
      repeat (PERIOD) begin
        @(negedge clk);
        if (pwm_out) hi++;
      end
      chk("R4 duty 0 high ticks", hi, 0);
    end else begin
      prev = pwm_out;
      @(negedge clk);
      while (!(!prev && pwm_out) && guard < 9000) begin
        prev = pwm_out;
        @(negedge clk);
        guard++;
      end
      while (pwm_out && hi < 5000) begin hi++; @(negedge clk); end
      while (!pwm_out && lo < 5000) begin lo++; @(negedge clk); end
      chk("R3/R4/R5 high run", hi, d);
      chk("R2 low run", lo, PERIOD - d);
    end
    chk("R7 no underrun", int'(underrun), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm_out), 0);
    chk("R1 underrun in reset", int'(underrun), 0);
    chk("R1 ready in reset", int'(duty_ready), 1);
    rst_n  = 1'b1;
    enable = 1'b1;
    repeat (200) @(negedge clk);
    chk("R1 duty 0 after reset", int'(pwm_out), 0);

    for (int v = 0; v < NVEC; v++) begin
      offer(int'(DUTY_VEC[v]));
      measure(int'(DUTY_VEC[v]));
    end

    // R6: a second offer waits while the first is pending.
    offer(500);
    chk("R6 ready low while pending", int'(duty_ready), 0);
    offer(1000);
    measure(1000);

    // R8: starve the shifter.
    offer(4095);
    measure(4095);
    repeat (1000) @(negedge clk);
    enable = 1'b0;
    begin
      int wait_n = 0;
      int moved = 0;
      logic lvl;
      while (!underrun && wait_n < 300) begin @(negedge clk); wait_n++; end
      chk("R8 underrun raised", int'(underrun), 1);
      lvl = pwm_out;
      repeat (300) begin
        @(negedge clk);
        if (pwm_out != lvl) moved++;
      end
      chk("R8 level held while starved", moved, 0);
    end
    enable = 1'b1;
    repeat (200) @(negedge clk);
    chk("R8 underrun sticky", int'(underrun), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule